// File: doc/BRIEF.md
# Bus Read-Cycle Handshake Controller

This block runs the read cycle between a bus master and a slow peripheral as a pair of four-phase handshakes, clocked by a local clock. The master raises a request and waits for an acknowledge. The controller then strobes the device and waits for the device's acknowledge. It opens the data latch, and only then acknowledges the master. When the request drops, the controller closes the latch. It then releases the master's acknowledge and the device strobe. The device drops its own acknowledge last.

Both inputs are asynchronous and pass through flop synchronizers. In the default concurrent mode, a new request may arrive while the device side is still releasing. An internal arming bit tells a fresh request apart from the moment just before the latch opens: it is set only once the device side is fully idle, and it clears when the latch closes. A parameter selects a reduced variant instead. That variant has no arming bit and expects the master to wait until the strobe has dropped. A sticky error flag records input edges that the protocol does not allow. A counter counts completed cycles.

Top module: `rdcyc_ctrl`

## Requirements
- R1: A synchronous active-high reset drives all three handshake outputs, the error flag and the cycle count to 0.
- R2: During the rising phase, the strobe rises after a request is seen. The latch enable rises only after the device acknowledge is seen while the strobe is high. The bus acknowledge rises only after the latch enable is high.
- R3: After the request falls, the latch enable falls first. The bus acknowledge falls one cycle later and the strobe one cycle after that. Neither falls while the latch enable is high.
- R4: A new request seen while the device acknowledge is still high leaves the strobe low. The strobe rises again only once the device acknowledge is low and the request is high.
- R5: At most one of bus acknowledge, strobe and latch enable changes in any clock cycle.
- R6: A device acknowledge rising edge seen while the strobe is low sets the error flag. Otherwise that edge has no effect on the outputs.
- R7: The error flag also sets on a request fall seen while the bus acknowledge is low, or a request rise seen while it is high. Once set, the flag stays set until reset.
- R8: The cycle count increments by one in the same cycle the bus acknowledge falls, and holds otherwise.
- R9: With CONCURRENT_RELEASE = 0, the same port sequence results for a master that waits for the strobe to drop before a new request.
- R10: Each input passes SYNC_STAGES flops before the sequencer acts on it. With SYNC_STAGES = 2, no output changes within two edges of an input change. The strobe is high by the fourth edge after a request from idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req_i | input | 1 | Read request from the master, asynchronous |
| dev_ack_i | input | 1 | Device acknowledge, asynchronous |
| bus_ack_o | output | 1 | Transfer acknowledge to the master |
| dev_strobe_o | output | 1 | Strobe to the device |
| latch_en_o | output | 1 | Data-latch enable |
| proto_err_o | output | 1 | Sticky protocol-error flag |
| cycle_cnt_o | output | CNT_W | Completed read cycles |

## Verification
The bench builds two copies side by side with SYNC_STAGES = 2 and CNT_W = 16: one with concurrent release and one with the reduced variant. Both are driven from the same inputs. This lets every port sequence be compared across both release policies. Edge-exact sampling covers the synchronizer latency and the one-change-per-cycle order. It also covers a new request arriving while the device acknowledge is still high.

// File: rtl/rdcyc_pkg.sv
package rdcyc_pkg;
  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_ARM,
    ACT_STB_UP,
    ACT_LAT_UP,
    ACT_ACK_UP,
    ACT_LAT_DN,
    ACT_ACK_DN,
    ACT_STB_DN
  } act_e;
endpackage

// File: rtl/rdcyc_sync.sv
module rdcyc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/rdcyc_seq.sv
module rdcyc_seq
  import rdcyc_pkg::*;
#(
  parameter bit CONCURRENT = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic rq,
  input  logic da,
  output logic ack_o,
  output logic stb_o,
  output logic lat_o,
  output act_e act_o
);
  logic gate_up;
  logic rel_ok;
  logic arm_ok;
  act_e act;

  generate
    if (CONCURRENT) begin : g_conc
      logic armed;
      always_ff @(posedge clk) begin
        if (rst)                    armed <= 1'b0;
        else if (act == ACT_ARM)    armed <= 1'b1;
        else if (act == ACT_LAT_DN) armed <= 1'b0;
      end
      assign gate_up = armed;
      assign rel_ok  = !armed;
      assign arm_ok  = !armed;
    end else begin : g_red
      assign gate_up = 1'b1;
      assign rel_ok  = !rq;
      assign arm_ok  = 1'b0;
    end
  endgenerate

  always_comb begin
    act = ACT_IDLE;
    if (lat_o && !rq)
      act = ACT_LAT_DN;
    else if (ack_o && !lat_o && !rq && rel_ok)
      act = ACT_ACK_DN;
    else if (stb_o && !lat_o && rel_ok)
      act = ACT_STB_DN;
    else if (rq && lat_o && !ack_o)
      act = ACT_ACK_UP;
    else if (rq && stb_o && da && !lat_o && !ack_o && gate_up)
      act = ACT_LAT_UP;
    else if (rq && !stb_o && !da && !lat_o && !ack_o && gate_up)
      act = ACT_STB_UP;
    else if (rq && arm_ok && !stb_o && !da && !lat_o && !ack_o)
      act = ACT_ARM;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack_o <= 1'b0;
      stb_o <= 1'b0;
      lat_o <= 1'b0;
    end else begin
      case (act)
        ACT_STB_UP: stb_o <= 1'b1;
        ACT_LAT_UP: lat_o <= 1'b1;
        ACT_ACK_UP: ack_o <= 1'b1;
        ACT_LAT_DN: lat_o <= 1'b0;
        ACT_ACK_DN: ack_o <= 1'b0;
        ACT_STB_DN: stb_o <= 1'b0;
        default: ;
      endcase
    end
  end

  assign act_o = act;
endmodule

// File: rtl/rdcyc_mon.sv
module rdcyc_mon
  import rdcyc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rq,
  input  logic             da,
  input  logic             ack,
  input  logic             stb,
  input  act_e             act,
  output logic             err_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic rq_d, da_d;
  logic bad;

  always_comb begin
    bad = 1'b0;
    if ( da && !da_d && !stb) bad = 1'b1;
    if (!da &&  da_d &&  stb) bad = 1'b1;
    if (!rq &&  rq_d && !ack) bad = 1'b1;
    if ( rq && !rq_d &&  ack) bad = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rq_d  <= 1'b0;
      da_d  <= 1'b0;
      err_o <= 1'b0;
      cnt_o <= '0;
    end else begin
      rq_d <= rq;
      da_d <= da;
      if (bad) err_o <= 1'b1;
      if (act == ACT_ACK_DN) cnt_o <= cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/rdcyc_ctrl.sv
module rdcyc_ctrl
  import rdcyc_pkg::*;
#(
  parameter int SYNC_STAGES        = 2,
  parameter int CNT_W              = 16,
  parameter bit CONCURRENT_RELEASE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_req_i,
  input  logic             dev_ack_i,
  output logic             bus_ack_o,
  output logic             dev_strobe_o,
  output logic             latch_en_o,
  output logic             proto_err_o,
  output logic [CNT_W-1:0] cycle_cnt_o
);
  logic rq_s, da_s;
  act_e act;

  rdcyc_sync #(.STAGES(SYNC_STAGES)) u_sync_rq (
    .clk(clk), .rst(rst), .d(bus_req_i), .q(rq_s)
  );
  rdcyc_sync #(.STAGES(SYNC_STAGES)) u_sync_da (
    .clk(clk), .rst(rst), .d(dev_ack_i), .q(da_s)
  );

  rdcyc_seq #(.CONCURRENT(CONCURRENT_RELEASE)) u_seq (
    .clk(clk), .rst(rst), .rq(rq_s), .da(da_s),
    .ack_o(bus_ack_o), .stb_o(dev_strobe_o), .lat_o(latch_en_o), .act_o(act)
  );

  rdcyc_mon #(.CNT_W(CNT_W)) u_mon (
    .clk(clk), .rst(rst), .rq(rq_s), .da(da_s),
    .ack(bus_ack_o), .stb(dev_strobe_o), .act(act),
    .err_o(proto_err_o), .cnt_o(cycle_cnt_o)
  );
endmodule

// File: rtl/rdcyc_ctrl_chk.sv
module rdcyc_ctrl_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             ack,
  input logic             stb,
  input logic             lat,
  input logic             err,
  input logic [CNT_W-1:0] cnt
);
  // R5
  one_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({ack, stb, lat} ^ $past({ack, stb, lat})) <= 1);

  // R2
  lat_needs_stb_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(lat) |-> stb && !ack);

  // R2
  ack_needs_lat_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ack) |-> lat);

  // R3
  lat_first_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(ack) || $fell(stb)) |-> !lat);

  // R4
  stb_clean_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stb) |-> !ack && !lat);

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ack) |-> cnt == $past(cnt) + 1'b1);

  // R8
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$fell(ack) |-> $stable(cnt));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

bind rdcyc_ctrl rdcyc_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ack(bus_ack_o), .stb(dev_strobe_o),
  .lat(latch_en_o), .err(proto_err_o), .cnt(cycle_cnt_o)
);

// File: tb/rdcyc_ctrl_tb.sv
`timescale 1ns/1ps
module rdcyc_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic dack = 1'b0;
  logic ack_c, stb_c, lat_c, err_c;
  logic ack_r, stb_r, lat_r, err_r;
  logic [15:0] cnt_c, cnt_r;
  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rdcyc_ctrl #(.SYNC_STAGES(2), .CNT_W(16), .CONCURRENT_RELEASE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .bus_req_i(req), .dev_ack_i(dack),
    .bus_ack_o(ack_c), .dev_strobe_o(stb_c), .latch_en_o(lat_c),
    .proto_err_o(err_c), .cycle_cnt_o(cnt_c)
  );

  rdcyc_ctrl #(.SYNC_STAGES(2), .CNT_W(16), .CONCURRENT_RELEASE(1'b0)) u_dut_red (
    .clk(clk), .rst(rst), .bus_req_i(req), .dev_ack_i(dack),
    .bus_ack_o(ack_r), .dev_strobe_o(stb_r), .latch_en_o(lat_r),
    .proto_err_o(err_r), .cycle_cnt_o(cnt_r)
  );

  // fields: [4] req, [3] dack, [2] exp ack, [1] exp strobe, [0] exp latch
  localparam logic [4:0] VEC [8] = '{
    5'b10_010, 5'b11_111, 5'b01_000, 5'b11_000,
    5'b10_010, 5'b11_111, 5'b01_000, 5'b00_000
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic chk_both(input string tag, input logic [2:0] exp);
    chk({tag, " concurrent"}, {13'd0, ack_c, stb_c, lat_c}, {13'd0, exp});
    chk({tag, " R9 reduced"}, {13'd0, ack_r, stb_r, lat_r}, {13'd0, exp});
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; req = 1'b0; dack = 1'b0;
    edges(2);
    rst = 1'b0;
  endtask

  function automatic string vec_tag(input int i);
    case (i)
      0, 1, 5: return "R2 table";
      2, 6:    return "R3 table";
      3, 4:    return "R4 table";
      default: return "R3 table idle";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    edges(3);
    // R1 reset state
    chk_both("R1 outputs", 3'b000);
    chk("R1 err", {14'd0, err_c, err_r}, 16'd0);
    chk("R1 cnt concurrent", cnt_c, 16'd0);
    chk("R1 cnt reduced", cnt_r, 16'd0);
    rst = 1'b0;
    edges(2);

    // R10 latency, R2 rising order, R3 falling order
    req = 1'b1;
    edges(2);
    chk_both("R10 no early strobe", 3'b000);
    edges(2);
    chk_both("R10 R2 strobe up", 3'b010);
    dack = 1'b1;
    edges(3);
    chk_both("R2 latch before ack", 3'b011);
    edges(1);
    chk_both("R2 ack up", 3'b111);
    req = 1'b0;
    edges(3);
    chk_both("R3 latch falls first", 3'b110);
    edges(1);
    chk_both("R3 R5 ack falls next", 3'b010);
    edges(1);
    chk_both("R3 strobe falls last", 3'b000);
    dack = 1'b0;
    edges(4);

    // vector table
    for (int i = 0; i < 8; i++) begin
      req  = VEC[i][4];
      dack = VEC[i][3];
      edges(8);
      chk_both(vec_tag(i), VEC[i][2:0]);
    end

    // R8 three completed cycles
    chk("R8 cnt concurrent", cnt_c, 16'd3);
    chk("R8 cnt reduced", cnt_r, 16'd3);
    chk("R7 no false error", {14'd0, err_c, err_r}, 16'd0);

    // R6 stray device acknowledge
    dack = 1'b1;
    edges(5);
    chk("R6 err set", {14'd0, err_c, err_r}, 16'd3);
    chk_both("R6 outputs untouched", 3'b000);
    dack = 1'b0;
    edges(5);
    chk("R7 err sticky", {14'd0, err_c, err_r}, 16'd3);

    do_reset();
    edges(1);
    chk("R1 err cleared", {14'd0, err_c, err_r}, 16'd0);
    chk("R1 cnt cleared", cnt_c, 16'd0);

    // R7 request withdrawn before acknowledge
    req = 1'b1;
    edges(6);
    chk_both("R7 strobe up", 3'b010);
    req = 1'b0;
    edges(5);
    chk("R7 early withdraw", {14'd0, err_c, err_r}, 16'd3);

    do_reset();
    edges(1);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule